// File: doc/BRIEF.md
# Integer square root unit

A sequential unit that takes a 16-bit unsigned operand (the contents of register R1), computes the floor of its square root and the leftover `operand - root*root`, and hands both back with write enables aimed at a register file: the root goes to R0, the leftover replaces the operand in R1, and R3 is cleared. R2 is never given a write port. A zero flag reports whether the root came out as zero.

The unit resolves two operand bits per step with the restoring digit-by-digit method, so a 16-bit operand takes eight steps. A `start` pulse while idle latches the operand. `busy` stays high through the steps and then drops in the same cycle that `done` pulses for exactly one clock. The result ports and write enables are meant to be consumed in that `done` cycle. Register storage and instruction decode sit outside the block.

Top module: `isqrt_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `r0_we`, `r1_we` and `r3_we` are all low.
- R2: A `start` sampled high at a rising edge while `busy` is low latches `operand`. `busy` is high after that edge, and `done` rises at the ninth rising edge, counting the one that sampled `start`.
- R3: `done` is high for exactly one cycle, and `busy` is low in that cycle. `busy` never falls without `done` rising.
- R4: In the `done` cycle, `r0_data` holds floor(sqrt(operand)) in bits [7:0], with bits [15:8] zero.
- R5: In the `done` cycle, `r1_data` holds `operand - root*root`, which never exceeds `2*root`.
- R6: `r0_we`, `r1_we` and `r3_we` are high only in the `done` cycle, and `r3_data` is zero in that cycle.
- R7: In the `done` cycle, `zero_flag` is 1 exactly when the root is 0.
- R8: While `busy` is high, `start` and any change on `operand` are ignored. The result belongs to the operand that was latched.
- R9: Operand 0x0000 gives root 0 and remainder 0. Operand 0xFFFF gives root 255 and remainder 510.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a computation when idle |
| operand | input | 16 | Unsigned value to take the root of (R1 contents) |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| r0_we | output | 1 | Write enable for R0 (root) |
| r0_data | output | 16 | Root, zero-extended |
| r1_we | output | 1 | Write enable for R1 (remainder) |
| r1_data | output | 16 | Remainder, zero-extended |
| r3_we | output | 1 | Write enable for R3 (cleared) |
| r3_data | output | 16 | Value for R3, always zero |
| zero_flag | output | 1 | Root equals zero, valid with `done` |

## Verification
A wrong step count in the controller moves the `done` edge away from the ninth edge. The bench measures that edge on every operation, so such a fault shows within a single operation. A corrupted root or remainder bit in any step spreads into every later step and shows as a wrong `r0_data` or `r1_data` at the next `done`. Operands that exercise both outcomes of each trial subtraction reach this quickly, among them 0, 0xFFFF, perfect squares, and a perfect square minus one. A latch that reloads while busy appears as the result of a second operand, which the bench provokes by pulsing `start` mid-computation.

// File: rtl/isqrt_pkg.sv
// Package: shared sizing helpers for the integer square root unit.
// Assumes the operand width is even, so the root has half its bits.
package isqrt_pkg;

    // Number of root bits (and of steps) for a given operand width
    function automatic int root_bits(input int data_w);
        return data_w / 2;
    endfunction

    // Width of the partial remainder: root bits plus room for shift-in
    function automatic int rem_bits(input int data_w);
        return data_w / 2 + 3;
    endfunction

endpackage

// File: rtl/isqrt_step.sv
// Module: isqrt_step
// One restoring step of the digit-by-digit square root. It shifts two
// operand bits into the partial remainder, compares against the trial
// value (root << 2 | 1) and decides one root bit.
// Assumes the incoming remainder is at most 2*root_in, so its top two
// bits are zero and may be shifted out.
module isqrt_step #(
    parameter int HALF_W = 8,
    parameter int REM_W  = HALF_W + 3
) (
    input  logic [REM_W-1:0]  rem_in,
    input  logic [HALF_W-1:0] root_in,
    input  logic [1:0]        pair,
    output logic [REM_W-1:0]  rem_out,
    output logic [HALF_W-1:0] root_out
);
    logic [REM_W-1:0] widened;
    logic [REM_W-1:0] trial;
    logic             fits;

    // Form the shifted remainder and trial value, then restore or subtract
    always_comb begin
        widened  = {rem_in[REM_W-3:0], pair};
        trial    = {{(REM_W-HALF_W-2){1'b0}}, root_in, 2'b01};
        fits     = (widened >= trial);
        rem_out  = fits ? (widened - trial) : widened;
        root_out = {root_in[HALF_W-2:0], fits};
    end
endmodule

// File: rtl/isqrt_ctrl.sv
// Module: isqrt_ctrl
// Sequencer: accepts start when idle, runs ITERS step cycles with busy
// high, then drops busy and raises done for one cycle.
// Assumes start is a level sampled on the rising edge; start while busy
// is dropped.
module isqrt_ctrl #(
    parameter int ITERS = 8,
    localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step_en,
    output logic last_step,
    output logic busy,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

    logic [CNT_W-1:0] step_cnt;

    // Decode handshakes from the current state
    always_comb begin
        load      = start && !busy;
        step_en   = busy;
        last_step = busy && (step_cnt == LAST);
    end

    // Step counter, busy and done registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= last_step;
            if (load) begin
                busy     <= 1'b1;
                step_cnt <= '0;
            end else if (last_step) begin
                busy     <= 1'b0;
                step_cnt <= '0;
            end else if (busy) begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    // R3
    // done_single_chk
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    // done_idle_chk
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R3
    // busy_end_chk
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    // start_accept_chk
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R8
    // restart_ignored_chk
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_step) |=> (busy && $stable(done)));
endmodule

// File: rtl/isqrt_unit.sv
// Module: isqrt_unit
// Integer square root of an unsigned DATA_W-bit operand. It produces the
// floor root (for R0), the remainder (for R1) and a zero value for R3,
// each with a write enable valid in the one-cycle done pulse. R2 has no
// write port. Assumes DATA_W is even and at least 4.
module isqrt_unit
    import isqrt_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] operand,
    output logic              busy,
    output logic              done,
    output logic              r0_we,
    output logic [DATA_W-1:0] r0_data,
    output logic              r1_we,
    output logic [DATA_W-1:0] r1_data,
    output logic              r3_we,
    output logic [DATA_W-1:0] r3_data,
    output logic              zero_flag
);
    localparam int HALF_W = root_bits(DATA_W);
    localparam int REM_W  = rem_bits(DATA_W);
    localparam int ITERS  = HALF_W;

    logic              load;
    logic              step_en;
    logic              last_step;
    logic [DATA_W-1:0] src_q;
    logic [REM_W-1:0]  rem_q;
    logic [HALF_W-1:0] root_q;
    logic              zero_q;
    logic [REM_W-1:0]  rem_nx;
    logic [HALF_W-1:0] root_nx;

    isqrt_ctrl #(.ITERS(ITERS)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load      (load),
        .step_en   (step_en),
        .last_step (last_step),
        .busy      (busy),
        .done      (done)
    );

    isqrt_step #(.HALF_W(HALF_W), .REM_W(REM_W)) u_step (
        .rem_in   (rem_q),
        .root_in  (root_q),
        .pair     (src_q[DATA_W-1 -: 2]),
        .rem_out  (rem_nx),
        .root_out (root_nx)
    );

    // Operand shifter and partial root/remainder registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            rem_q  <= '0;
            root_q <= '0;
            zero_q <= 1'b0;
        end else if (load) begin
            src_q  <= operand;
            rem_q  <= '0;
            root_q <= '0;
        end else if (step_en) begin
            src_q  <= {src_q[DATA_W-3:0], 2'b00};
            rem_q  <= rem_nx;
            root_q <= root_nx;
            zero_q <= (root_nx == '0);
        end
    end

    // Map results onto the register-file write ports
    always_comb begin
        r0_we     = done;
        r1_we     = done;
        r3_we     = done;
        r0_data   = {{(DATA_W-HALF_W){1'b0}}, root_q};
        r1_data   = {{(DATA_W-HALF_W-1){1'b0}}, rem_q[HALF_W:0]};
        r3_data   = '0;
        zero_flag = zero_q;
    end

    // R5
    // rem_bound_chk
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem_q <= {root_q, 1'b0}));

    // R7
    // zero_flag_chk
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (zero_flag == (root_q == '0)));

    // R8
    // hold_while_done_chk
    hold_while_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(root_q) && $stable(rem_q));
endmodule

// File: tb/test_isqrt_unit.sv
module test_isqrt_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] operand = '0;
    logic        busy, done, r0_we, r1_we, r3_we, zero_flag;
    logic [15:0] r0_data, r1_data, r3_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    isqrt_unit i_isqrt_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .busy(busy), .done(done),
        .r0_we(r0_we), .r0_data(r0_data),
        .r1_we(r1_we), .r1_data(r1_data),
        .r3_we(r3_we), .r3_data(r3_data),
        .zero_flag(zero_flag)
    );

    function automatic int ref_root(input int x);
        int r = 0;
        while ((r + 1) * (r + 1) <= x) r++;
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One operation; poke pulses start with another operand while busy
    task automatic run_op(input logic [15:0] x, input bit poke);
        int lat;
        int er, em;
        bit busy_ok;
        er = ref_root(int'(x));
        em = int'(x) - er * er;
        @(negedge clk);
        start = 1'b1;
        operand = x;
        @(negedge clk);
        start = 1'b0;
        operand = 16'($urandom);
        lat = 1;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        busy_ok = 1;
        while (!done && lat < 20) begin
            if (!busy) busy_ok = 0;
            if (r0_we || r1_we || r3_we) busy_ok = 0;
            if (poke && lat == 3) begin
                start = 1'b1;
                operand = ~x;
            end
            @(negedge clk);
            start = 1'b0;
            operand = 16'($urandom);
            lat++;
        end
        check(busy_ok, "R6 busy held, no write enable early", 0, 1);
        check(lat == 9, "R2 done latency", lat, 9);
        check(busy == 1'b0, "R3 busy low with done", int'(busy), 0);
        check(r0_data == 16'(er), poke ? "R8 root after restart attempt" : "R4 root", int'(r0_data), er);
        check(r1_data == 16'(em), "R5 remainder", int'(r1_data), em);
        check(r0_we && r1_we && r3_we && r3_data == 16'h0, "R6 write enables and r3_data", int'(r3_data), 0);
        check(zero_flag == (er == 0), "R7 zero flag", int'(zero_flag), int'(er == 0));
        @(negedge clk);
        check(!done && !r0_we && !r1_we && !r3_we, "R3 done single cycle", int'(done), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=expired expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check(!busy && !done && !r0_we && !r1_we && !r3_we, "R1 reset state", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after reset", int'(done), 0);
        // R9 corner operands
        run_op(16'h0000, 0);
        run_op(16'hFFFF, 0);
        run_op(16'h0001, 0);
        run_op(16'h0004, 0);
        run_op(16'h0003, 0);
        run_op(16'hFE01, 0);
        run_op(16'hFE00, 0);
        run_op(16'h4000, 0);
        // R8 start while busy
        run_op(16'h0090, 1);
        run_op(16'hFFFF, 1);
        for (int i = 0; i < 300; i++) begin
            run_op(16'($urandom), (i % 7) == 0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule